// File: doc/BRIEF.md
# General-Purpose Event and Slot Hot-Plug Register Block

This block holds the registers that tell system software about hot-plug activity on a set of expansion slots. A 16-bit event status register and a 16-bit event enable register are reached one byte at a time through a small byte port. A separate word port reaches two slot bitmaps, one for insertions and one for removals, and an eject register through which software reports that it has released a slot.

Hardware reports a hot-plug event with a one-cycle strobe that carries a slot number and an add-or-remove flag. The event replaces the contents of both bitmaps, so only the newest slot is shown, and sets the hot-plug bit of the event status. If the matching enable bit is set, a one-cycle system control interrupt pulse is raised. When software writes the eject register, the block turns the written mask into the index of its lowest set bit and sends that index out on a one-cycle completion strobe. Slot power control and wider I/O address decoding are outside this block.

Top module: `gpe_hotplug_regs`

## Requirements
- R1: After reset every status, enable and bitmap bit reads 0, and sci_pulse and eject_done are low.
- R2: A byte write to offset 0 (status bits 7:0) or offset 1 (status bits 15:8) clears each status bit of that byte whose write-data bit is 1 and leaves every other status bit unchanged.
- R3: A byte write to offset 2 (enable bits 7:0) or offset 3 (enable bits 15:8) replaces that byte of the enable register and leaves the other byte unchanged; no other access changes the enable register.
- R4: A hot-plug event clears both bitmaps, then sets bit evt_slot of the insert bitmap when evt_add is 1 or of the remove bitmap when evt_add is 0, and sets status bit 1; the new values are readable from the cycle after the event and take precedence over a bitmap write in the same cycle.
- R5: sci_pulse is high in the cycle after an event exactly when enable bit 1 was set at the event, and stays high for that single cycle only.
- R6: Word 0 of the word port is the insert bitmap and word 1 the remove bitmap; both can be written and read back in full.
- R7: A write to word 2 (eject) with a nonzero value raises eject_done for one cycle in the following cycle with eject_slot equal to the index of the lowest set bit of the written value; a write of 0 raises no strobe.
- R8: Reads of word 2 and word 3 return 0; read data on both ports appears in the cycle after the read strobe.
- R9: When an event and a software clear of status bit 1 arrive in the same cycle, status bit 1 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpe_wr | input | 1 | Byte port write strobe |
| gpe_rd | input | 1 | Byte port read strobe |
| gpe_addr | input | 2 | Byte offset: 0/1 status, 2/3 enable |
| gpe_wdata | input | 8 | Byte write data |
| gpe_rdata | output | 8 | Registered byte read data |
| hp_wr | input | 1 | Word port write strobe |
| hp_rd | input | 1 | Word port read strobe |
| hp_word | input | 2 | Word select: 0 insert, 1 remove, 2 eject, 3 reserved |
| hp_wdata | input | 32 | Word write data |
| hp_rdata | output | 32 | Registered word read data |
| evt_valid | input | 1 | Hot-plug event strobe |
| evt_slot | input | 5 | Slot number of the event |
| evt_add | input | 1 | 1 for insertion, 0 for removal |
| sci_pulse | output | 1 | One-cycle interrupt pulse |
| eject_done | output | 1 | One-cycle release strobe |
| eject_slot | output | 5 | Slot index carried by eject_done |

## Verification
A status bit held wrongly shows up on the next byte read of offset 0 or 1, and a wrong enable bit shows up either on the next read of offsets 2 or 3 or as a missing or extra sci_pulse one cycle after an event. A bitmap that keeps a stale slot after an event, or loses one to a software write in the same cycle, is visible on the very next word read. A wrong priority encoding is seen on eject_slot in the cycle right after the eject write, and a strobe on a zero write is seen in that same cycle.

// File: rtl/gpe_hp_pkg.sv
package gpe_hp_pkg;
  typedef enum logic [1:0] {
    HP_WORD_INS   = 2'd0,
    HP_WORD_REM   = 2'd1,
    HP_WORD_EJECT = 2'd2,
    HP_WORD_RSVD  = 2'd3
  } hp_word_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/gpe_byte_regs.sv
module gpe_byte_regs #(
  parameter int unsigned GPE_W  = 16,
  parameter int unsigned HP_BIT = 1,
  localparam int unsigned NBYTES = GPE_W / 8,
  localparam int unsigned ADDR_W = $clog2(2 * NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              hw_set,
  output logic [7:0]        rdata,
  output logic [GPE_W-1:0]  sts,
  output logic [GPE_W-1:0]  en
);
  logic [GPE_W-1:0] sts_q, sts_d;
  logic [GPE_W-1:0] en_q, en_d;
  logic [7:0]       rd_mux;
  logic [7:0]       rdata_q;

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    for (int b = 0; b < int'(NBYTES); b++) begin
      if (wr && addr == ADDR_W'(b))
        sts_d[b*8 +: 8] = sts_q[b*8 +: 8] & ~wdata;
      if (wr && addr == ADDR_W'(NBYTES + b))
        en_d[b*8 +: 8] = wdata;
    end
    if (hw_set)
      sts_d[HP_BIT] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < int'(NBYTES); b++) begin
      if (addr == ADDR_W'(b))          rd_mux = sts_q[b*8 +: 8];
      if (addr == ADDR_W'(NBYTES + b)) rd_mux = en_q[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= '0;
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign sts   = sts_q;
  assign en    = en_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/slot_bitmaps.sv
module slot_bitmaps
  import gpe_hp_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [1:0]           word,
  input  logic [NUM_SLOTS-1:0] wdata,
  input  logic                 evt_valid,
  input  logic [SLOT_W-1:0]    evt_slot,
  input  logic                 evt_add,
  output logic [NUM_SLOTS-1:0] ins,
  output logic [NUM_SLOTS-1:0] rem,
  output logic [NUM_SLOTS-1:0] rdata
);
  logic [NUM_SLOTS-1:0] ins_q, rem_q, rdata_q, onehot;

  assign onehot = NUM_SLOTS'(1) << evt_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q   <= '0;
      rem_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (evt_valid) begin
        ins_q <= evt_add ? onehot : '0;
        rem_q <= evt_add ? '0 : onehot;
      end else if (wr) begin
        if (word == HP_WORD_INS) ins_q <= wdata;
        if (word == HP_WORD_REM) rem_q <= wdata;
      end
      if (rd) begin
        case (hp_word_e'(word))
          HP_WORD_INS: rdata_q <= ins_q;
          HP_WORD_REM: rdata_q <= rem_q;
          default:     rdata_q <= '0;
        endcase
      end
    end
  end

  assign ins   = ins_q;
  assign rem   = rem_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/lowest_set_encoder.sv
module lowest_set_encoder #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign found = |vec;
endmodule

// File: rtl/gpe_hotplug_regs.sv
module gpe_hotplug_regs
  import gpe_hp_pkg::*;
#(
  parameter int unsigned GPE_W     = 16,
  parameter int unsigned HP_BIT    = 1,
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned GADDR_W  = $clog2(2 * (GPE_W / 8)),
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gpe_wr,
  input  logic                 gpe_rd,
  input  logic [GADDR_W-1:0]   gpe_addr,
  input  logic [7:0]           gpe_wdata,
  output logic [7:0]           gpe_rdata,
  input  logic                 hp_wr,
  input  logic                 hp_rd,
  input  logic [1:0]           hp_word,
  input  logic [NUM_SLOTS-1:0] hp_wdata,
  output logic [NUM_SLOTS-1:0] hp_rdata,
  input  logic                 evt_valid,
  input  logic [SLOT_W-1:0]    evt_slot,
  input  logic                 evt_add,
  output logic                 sci_pulse,
  output logic                 eject_done,
  output logic [SLOT_W-1:0]    eject_slot
);
  logic [GPE_W-1:0]     gpe_sts, gpe_en;
  logic [NUM_SLOTS-1:0] slot_ins, slot_rem;
  logic                 enc_found;
  logic [SLOT_W-1:0]    enc_idx;
  logic                 sci_q, done_q;
  logic [SLOT_W-1:0]    done_slot_q;

  gpe_byte_regs #(.GPE_W(GPE_W), .HP_BIT(HP_BIT)) u_gpe (
    .clk(clk), .rst(rst), .wr(gpe_wr), .rd(gpe_rd), .addr(gpe_addr),
    .wdata(gpe_wdata), .hw_set(evt_valid), .rdata(gpe_rdata),
    .sts(gpe_sts), .en(gpe_en)
  );

  slot_bitmaps #(.NUM_SLOTS(NUM_SLOTS)) u_bitmaps (
    .clk(clk), .rst(rst), .wr(hp_wr), .rd(hp_rd), .word(hp_word),
    .wdata(hp_wdata), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_add(evt_add), .ins(slot_ins), .rem(slot_rem), .rdata(hp_rdata)
  );

  lowest_set_encoder #(.W(NUM_SLOTS)) u_enc (
    .vec(hp_wdata), .found(enc_found), .idx(enc_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_q       <= 1'b0;
      done_q      <= 1'b0;
      done_slot_q <= '0;
    end else begin
      sci_q  <= evt_valid & gpe_en[HP_BIT];
      done_q <= hp_wr && (hp_word == HP_WORD_EJECT) && enc_found;
      if (hp_wr && (hp_word == HP_WORD_EJECT) && enc_found)
        done_slot_q <= enc_idx;
    end
  end

  assign sci_pulse  = sci_q;
  assign eject_done = done_q;
  assign eject_slot = done_slot_q;
endmodule

// File: rtl/gpe_hotplug_regs_chk.sv
module gpe_hotplug_regs_chk #(
  parameter int unsigned GPE_W     = 16,
  parameter int unsigned HP_BIT    = 1,
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned GADDR_W  = $clog2(2 * (GPE_W / 8)),
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 gpe_wr,
  input logic [GADDR_W-1:0]   gpe_addr,
  input logic [7:0]           gpe_wdata,
  input logic                 hp_wr,
  input logic [1:0]           hp_word,
  input logic [NUM_SLOTS-1:0] hp_wdata,
  input logic                 evt_valid,
  input logic                 sci_pulse,
  input logic                 eject_done,
  input logic [SLOT_W-1:0]    eject_slot,
  input logic [GPE_W-1:0]     gpe_sts,
  input logic [GPE_W-1:0]     gpe_en,
  input logic [NUM_SLOTS-1:0] slot_ins,
  input logic [NUM_SLOTS-1:0] slot_rem
);
  localparam int unsigned NB = GPE_W / 8;
  logic                 past_ok;
  logic                 last_ej_nz;
  logic [NUM_SLOTS-1:0] last_wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok    <= 1'b0;
      last_ej_nz <= 1'b0;
      last_wd    <= '0;
    end else begin
      past_ok    <= 1'b1;
      last_ej_nz <= hp_wr && hp_word == 2'd2 && hp_wdata != '0;
      last_wd    <= hp_wdata;
    end
  end

  assert_sci_cause_R5: assert property (@(posedge clk) disable iff (rst)
    sci_pulse |-> past_ok && $past(evt_valid && gpe_en[HP_BIT]));

  assert_sci_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && gpe_en[HP_BIT]) |=> sci_pulse);

  assert_evt_status_R4: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> gpe_sts[HP_BIT]);

  assert_evt_single_slot_R4: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> $onehot({slot_ins, slot_rem}));

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && gpe_wr && gpe_addr == '0 && gpe_wdata[HP_BIT]) |=> gpe_sts[HP_BIT]);

  assert_enable_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(gpe_wr && gpe_addr >= GADDR_W'(NB)) |=> $stable(gpe_en));

  assert_eject_cause_R7: assert property (@(posedge clk) disable iff (rst)
    eject_done |-> last_ej_nz);

  assert_eject_lowest_R7: assert property (@(posedge clk) disable iff (rst)
    eject_done |-> (last_wd[eject_slot] &&
                    (last_wd & ((NUM_SLOTS'(1) << eject_slot) - NUM_SLOTS'(1))) == '0));
endmodule

bind gpe_hotplug_regs gpe_hotplug_regs_chk #(
  .GPE_W(GPE_W), .HP_BIT(HP_BIT), .NUM_SLOTS(NUM_SLOTS)
) chk_i (
  .clk(clk), .rst(rst), .gpe_wr(gpe_wr), .gpe_addr(gpe_addr),
  .gpe_wdata(gpe_wdata), .hp_wr(hp_wr), .hp_word(hp_word),
  .hp_wdata(hp_wdata), .evt_valid(evt_valid), .sci_pulse(sci_pulse),
  .eject_done(eject_done), .eject_slot(eject_slot), .gpe_sts(gpe_sts),
  .gpe_en(gpe_en), .slot_ins(slot_ins), .slot_rem(slot_rem)
);

// File: tb/gpe_hotplug_regs_tb_top.sv
`timescale 1ns/1ps
module gpe_hotplug_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gpe_wr = 0, gpe_rd = 0;
  logic [1:0]  gpe_addr = '0;
  logic [7:0]  gpe_wdata = '0;
  logic [7:0]  gpe_rdata;
  logic        hp_wr = 0, hp_rd = 0;
  logic [1:0]  hp_word = '0;
  logic [31:0] hp_wdata = '0;
  logic [31:0] hp_rdata;
  logic        evt_valid = 0, evt_add = 0;
  logic [4:0]  evt_slot = '0;
  logic        sci_pulse, eject_done;
  logic [4:0]  eject_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpe_hotplug_regs dut_i (
    .clk(clk), .rst(rst), .gpe_wr(gpe_wr), .gpe_rd(gpe_rd),
    .gpe_addr(gpe_addr), .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata),
    .hp_wr(hp_wr), .hp_rd(hp_rd), .hp_word(hp_word), .hp_wdata(hp_wdata),
    .hp_rdata(hp_rdata), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_add(evt_add), .sci_pulse(sci_pulse), .eject_done(eject_done),
    .eject_slot(eject_slot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic gpe_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); gpe_wr = 1; gpe_addr = a; gpe_wdata = d;
    @(posedge clk); #1 gpe_wr = 0;
  endtask

  task automatic gpe_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); gpe_rd = 1; gpe_addr = a;
    @(posedge clk); #1 d = gpe_rdata; gpe_rd = 0;
  endtask

  task automatic hp_write(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk); hp_wr = 1; hp_word = w; hp_wdata = d;
    @(posedge clk); #1 hp_wr = 0;
  endtask

  task automatic hp_read(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk); hp_rd = 1; hp_word = w;
    @(posedge clk); #1 d = hp_rdata; hp_rd = 0;
  endtask

  task automatic hp_event(input logic [4:0] s, input logic add,
                          output logic sci_now, output logic sci_next);
    @(negedge clk); evt_valid = 1; evt_slot = s; evt_add = add;
    @(posedge clk); #1 sci_now = sci_pulse; evt_valid = 0;
    @(posedge clk); #1 sci_next = sci_pulse;
  endtask

  task automatic eject(input logic [31:0] v, output logic dv, output logic [4:0] ds);
    @(negedge clk); hp_wr = 1; hp_word = 2'd2; hp_wdata = v;
    @(posedge clk); #1 dv = eject_done; ds = eject_slot; hp_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] b; logic [31:0] w;
    for (int a = 0; a < 4; a++) begin
      gpe_read(2'(a), b); check("R1 gpe byte after reset", 32'(b), 0);
    end
    hp_read(2'd0, w); check("R1 insert after reset", w, 0);
    hp_read(2'd1, w); check("R1 remove after reset", w, 0);
    check("R1 sci low", 32'(sci_pulse), 0);
    check("R1 eject_done low", 32'(eject_done), 0);
  endtask

  task automatic t_enable_bytes();
    logic [7:0] b;
    gpe_write(2'd2, 8'hA5); gpe_write(2'd3, 8'h3C);
    gpe_read(2'd2, b); check("R3 enable low", 32'(b), 32'hA5);
    gpe_read(2'd3, b); check("R3 enable high", 32'(b), 32'h3C);
    gpe_write(2'd2, 8'h02);
    gpe_read(2'd3, b); check("R3 enable high kept", 32'(b), 32'h3C);
    gpe_read(2'd2, b); check("R3 enable low replaced", 32'(b), 32'h02);
    gpe_write(2'd0, 8'hFF);
    gpe_read(2'd2, b); check("R3 status write leaves enable", 32'(b), 32'h02);
  endtask

  task automatic t_add_event();
    logic s0, s1; logic [7:0] b; logic [31:0] w;
    hp_event(5'd7, 1'b1, s0, s1);
    check("R5 sci in cycle after event", 32'(s0), 1);
    check("R5 sci one cycle only", 32'(s1), 0);
    hp_read(2'd0, w); check("R4 insert bit 7", w, 32'h80);
    hp_read(2'd1, w); check("R4 remove empty", w, 0);
    gpe_read(2'd0, b); check("R4 status bit 1", 32'(b), 32'h02);
  endtask

  task automatic t_remove_event();
    logic s0, s1; logic [31:0] w;
    hp_event(5'd31, 1'b0, s0, s1);
    check("R5 sci on removal", 32'(s0), 1);
    hp_read(2'd0, w); check("R4 insert cleared", w, 0);
    hp_read(2'd1, w); check("R4 remove bit 31", w, 32'h8000_0000);
  endtask

  task automatic t_status_clear();
    logic [7:0] b;
    gpe_write(2'd1, 8'hFF);
    gpe_read(2'd0, b); check("R2 high-byte clear keeps low", 32'(b), 32'h02);
    gpe_write(2'd0, 8'h01);
    gpe_read(2'd0, b); check("R2 zero bits not cleared", 32'(b), 32'h02);
    gpe_write(2'd0, 8'h02);
    gpe_read(2'd0, b); check("R2 bit 1 cleared", 32'(b), 32'h00);
  endtask

  task automatic t_masked_event();
    logic s0, s1; logic [7:0] b; logic [31:0] w;
    gpe_write(2'd2, 8'h00);
    hp_event(5'd3, 1'b1, s0, s1);
    check("R5 no sci when disabled", 32'(s0), 0);
    check("R5 no late sci", 32'(s1), 0);
    gpe_read(2'd0, b); check("R4 status set while masked", 32'(b), 32'h02);
    hp_read(2'd0, w); check("R4 insert bit 3", w, 32'h8);
  endtask

  task automatic t_set_wins();
    logic [7:0] b; logic [31:0] w;
    gpe_write(2'd0, 8'h02);
    gpe_read(2'd0, b); check("R9 precondition clear", 32'(b), 0);
    @(negedge clk);
    evt_valid = 1; evt_slot = 5'd12; evt_add = 1;
    gpe_wr = 1; gpe_addr = 2'd0; gpe_wdata = 8'h02;
    hp_wr = 1; hp_word = 2'd0; hp_wdata = 32'hFFFF_0000;
    @(posedge clk); #1 evt_valid = 0; gpe_wr = 0; hp_wr = 0;
    gpe_read(2'd0, b); check("R9 set beats clear", 32'(b), 32'h02);
    hp_read(2'd0, w); check("R4 event beats bitmap write", w, 32'h1000);
  endtask

  task automatic t_bitmap_rw();
    logic [31:0] w;
    hp_write(2'd0, 32'hDEAD_BEEF);
    hp_write(2'd1, 32'h1234_5678);
    hp_read(2'd0, w); check("R6 insert readback", w, 32'hDEAD_BEEF);
    hp_read(2'd1, w); check("R6 remove readback", w, 32'h1234_5678);
  endtask

  task automatic t_eject();
    logic dv; logic [4:0] ds; logic [31:0] w;
    eject(32'h0000_00A0, dv, ds);
    check("R7 strobe on nonzero", 32'(dv), 1);
    check("R7 lowest bit 5", 32'(ds), 5);
    @(posedge clk); #1 check("R7 strobe one cycle", 32'(eject_done), 0);
    eject(32'h8000_0000, dv, ds);
    check("R7 top bit index", 32'(ds), 31);
    eject(32'hFFFF_FFFF, dv, ds);
    check("R7 all ones gives 0", 32'(ds), 0);
    eject(32'h0, dv, ds);
    check("R7 zero write no strobe", 32'(dv), 0);
    hp_read(2'd2, w); check("R8 eject reads 0", w, 0);
    hp_read(2'd3, w); check("R8 reserved reads 0", w, 0);
    hp_read(2'd1, w); check("R6 eject leaves remove", w, 32'h1234_5678);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_enable_bytes();
    t_add_event();
    t_remove_event();
    t_status_clear();
    t_masked_event();
    t_set_wins();
    t_bitmap_rw();
    t_eject();
    summary();
    $finish;
  end
endmodule